// File: doc/BRIEF.md
# Pin Event Timestamp Capture Unit

This unit records when things happen on an external pin. It watches an asynchronous input, brings it into the clock domain and finds its edges. On each edge that the selected mode treats as an event, it stores the current value of one of two free-running 16-bit counters. The counters themselves are supplied from outside. Stored stamps wait in a four-entry first-in first-out buffer until software reads them through a single read port, one stamp per read.

A small control word sets three things: the event mode, the counter the stamps are taken from, and the number of buffered stamps that raise an interrupt pulse. There are three edge modes: rising only, falling only, and both. There are two divided modes, which take one stamp for every 4th or every 16th rising edge. Status outputs show whether stamps are waiting and whether a stamp was lost because the buffer was full. Selecting an off code flushes the buffer and clears all status and counting state.

Top module: `tstamp_capture`

## Requirements
- R1: After reset, not_empty, overflow and irq are 0, rd_data is 0, and the unit is in the off mode (mode code 0).
- R2: With mode code 3 (ctl_wdata[2:0]=011), each rising pin edge stores one stamp, and falling edges store nothing.
- R3: With mode code 2, each falling pin edge stores one stamp, and rising edges store nothing.
- R4: With mode code 1, every pin edge of either polarity stores one stamp.
- R5: With mode code 4, one stamp is stored on every 4th rising edge. The count of rising edges starts from zero whenever a write changes the mode code.
- R6: With mode code 5, one stamp is stored on every 16th rising edge, counted in the same way as R5.
- R7: Control bit ctl_wdata[3] picks the stamp source: 0 takes tmr_a and 1 takes tmr_b. The stored value is the counter value in the clock cycle where the synchronized edge is seen.
- R8: Stamps come out oldest first, at most four are held, and not_empty is 1 while any are held. A read pulse on rd_en with stamps held loads the oldest stamp into rd_data on that clock edge and removes it.
- R9: A read while the buffer is empty leaves rd_data, not_empty and overflow unchanged.
- R10: An event that arrives with four stamps held is dropped and sets overflow. Overflow clears only on a read that removes a stamp or on entry to an off mode.
- R11: irq is a one-cycle pulse raised when the number of stamps stored since the last pulse reaches ctl_wdata[5:4]+1. Dropped events are not counted. The count restarts after each pulse and on every write that changes the mode code.
- R12: Mode codes 0, 6 and 7 are off: no stamps are taken, the buffer is emptied, overflow is cleared, and the divider and interrupt counts are reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 1 | Asynchronous event pin |
| tmr_a | input | 16 | First time base value |
| tmr_b | input | 16 | Second time base value |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | Control word: [2:0] mode, [3] source, [5:4] interrupt threshold minus one |
| rd_en | input | 1 | Read strobe for the stamp buffer |
| rd_data | output | 16 | Last stamp read |
| not_empty | output | 1 | Stamps are waiting |
| overflow | output | 1 | An event was lost to a full buffer |
| irq | output | 1 | Interrupt pulse |

## Verification
A wrong buffer pointer or a wrong occupancy count shows up at rd_data on the next read, either as a stamp out of order or as a stale stamp. The same fault often shows on not_empty or overflow one cycle after the capture that exposes it. A divider that does not restart on a mode change shifts the first divided stamp by whole pin pulses, so the error shows at not_empty within a few pulses. An interrupt counter that does not restart after a pulse or a mode change produces a pulse one or more captures early or late. The bench compares its running pulse count against its own model after every pin edge and every read, so such a fault is reported at the first comparison after it occurs.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;

  typedef enum logic [2:0] {
    MODE_OFF    = 3'd0,
    MODE_BOTH   = 3'd1,
    MODE_FALL   = 3'd2,
    MODE_RISE   = 3'd3,
    MODE_DIV_LO = 3'd4,
    MODE_DIV_HI = 3'd5,
    MODE_RSV6   = 3'd6,
    MODE_RSV7   = 3'd7
  } cap_mode_e;

  function automatic logic mode_is_off(cap_mode_e m);
    return (m == MODE_OFF) || (m == MODE_RSV6) || (m == MODE_RSV7);
  endfunction

endpackage

// File: rtl/tstamp_edge.sv
module tstamp_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic rise,
  output logic fall
);

  logic [STAGES:0] chain_q, chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-1:0], pin_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its history
  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall = ~chain_q[STAGES-1] & chain_q[STAGES];

endmodule

// File: rtl/tstamp_qual.sv
module tstamp_qual
  import tstamp_pkg::*;
#(
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  cap_mode_e mode,
  input  logic      restart,
  input  logic      rise,
  input  logic      fall,
  output logic      evt
);

  localparam int PSC_W = $clog2(DIV_HI);

  logic [PSC_W-1:0] psc_q, psc_d;
  logic             divided, hit;

  always_comb begin
    divided = (mode == MODE_DIV_LO) || (mode == MODE_DIV_HI);
    hit     = (mode == MODE_DIV_LO) ? (psc_q == PSC_W'(DIV_LO - 1))
                                    : (psc_q == PSC_W'(DIV_HI - 1));
    case (mode)
      MODE_BOTH:   evt = rise | fall;
      MODE_FALL:   evt = fall;
      MODE_RISE:   evt = rise;
      MODE_DIV_LO,
      MODE_DIV_HI: evt = rise & hit;
      default:     evt = 1'b0;
    endcase

    psc_d = psc_q;
    if (restart)              psc_d = '0;
    else if (divided && rise) psc_d = hit ? '0 : psc_q + PSC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc_q <= '0;
    else        psc_q <= psc_d;
  end

endmodule

// File: rtl/tstamp_fifo.sv
module tstamp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic         pop_req,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         not_empty,
  output logic         overflow,
  output logic         accept
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic [W-1:0]  dout_q, dout_d;
  logic          pop, full;

  always_comb begin
    full   = (cnt_q == CW'(DEPTH));
    pop    = pop_req && (cnt_q != '0);
    accept = push && !flush && (!full || pop);

    dout_d = pop ? mem_q[rp_q] : dout_q;
    wp_d   = wp_q;
    rp_d   = rp_q;
    cnt_d  = cnt_q;
    ovf_d  = ovf_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
      ovf_d = 1'b0;
    end else begin
      if (accept) wp_d = wp_q + PW'(1);
      if (pop)    rp_d = rp_q + PW'(1);
      cnt_d = cnt_q + CW'(accept) - CW'(pop);
      if (pop)                 ovf_d = 1'b0;
      else if (push && !accept) ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      dout_q <= '0;
    end else begin
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
      dout_q <= dout_d;
    end
  end

  // storage without reset, written only under its enable
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (accept && (wp_q == PW'(i))) mem_q[i] <= din;
    end
  end

  assign dout      = dout_q;
  assign not_empty = (cnt_q != '0);
  assign overflow  = ovf_q;

endmodule

// File: rtl/tstamp_capture.sv
module tstamp_capture
  import tstamp_pkg::*;
#(
  parameter  int TW          = 16,
  parameter  int DEPTH       = 4,
  parameter  int SYNC_STAGES = 2,
  parameter  int DIV_LO      = 4,
  parameter  int DIV_HI      = 16,
  localparam int THR_W       = $clog2(DEPTH),
  localparam int CTL_W       = 4 + THR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_pin,
  input  logic [TW-1:0]    tmr_a,
  input  logic [TW-1:0]    tmr_b,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             rd_en,
  output logic [TW-1:0]    rd_data,
  output logic             not_empty,
  output logic             overflow,
  output logic             irq
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  // control word
  cap_mode_e        mode_q, mode_d, wr_mode;
  logic             tsel_q, tsel_d;
  logic [THR_W-1:0] thr_q, thr_d;
  logic             mode_chg, mode_off;

  always_comb begin
    wr_mode  = cap_mode_e'(ctl_wdata[2:0]);
    mode_chg = ctl_wr && (wr_mode != mode_q);
    mode_off = mode_is_off(mode_q);
    mode_d   = ctl_wr ? wr_mode      : mode_q;
    tsel_d   = ctl_wr ? ctl_wdata[3] : tsel_q;
    thr_d    = ctl_wr ? ctl_wdata[CTL_W-1:4] : thr_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_q <= MODE_OFF;
      tsel_q <= 1'b0;
      thr_q  <= '0;
    end else begin
      mode_q <= mode_d;
      tsel_q <= tsel_d;
      thr_q  <= thr_d;
    end
  end

  // event path
  logic          rise, fall, evt, accept;
  logic [TW-1:0] stamp;

  tstamp_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pin_async (cap_pin),
    .rise      (rise),
    .fall      (fall)
  );

  tstamp_qual #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_qual (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .mode    (mode_q),
    .restart (mode_chg || mode_off),
    .rise    (rise),
    .fall    (fall),
    .evt     (evt)
  );

  assign stamp = tsel_q ? tmr_b : tmr_a;

  tstamp_fifo #(.W(TW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .flush     (mode_off),
    .push      (evt),
    .pop_req   (rd_en),
    .din       (stamp),
    .dout      (rd_data),
    .not_empty (not_empty),
    .overflow  (overflow),
    .accept    (accept)
  );

  // interrupt threshold counter
  logic [THR_W-1:0] icnt_q, icnt_d;
  logic             irq_q, irq_d;
  logic             fire;

  always_comb begin
    fire   = accept && (icnt_q >= thr_q);
    irq_d  = fire;
    icnt_d = icnt_q;
    if (mode_off || mode_chg) icnt_d = '0;
    else if (fire)            icnt_d = '0;
    else if (accept)          icnt_d = icnt_q + THR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      icnt_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      icnt_q <= icnt_d;
      irq_q  <= irq_d;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/tstamp_capture_chk.sv
module tstamp_capture_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic [TW-1:0] rd_data,
  input logic          not_empty,
  input logic          overflow,
  input logic          irq,
  input logic          mode_off
);

  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !not_empty) |=> $stable(rd_data));

  assert_ovf_holds_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> not_empty);

  assert_irq_has_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> not_empty);

  assert_off_flushes_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mode_off |=> (!not_empty && !overflow));

  assert_irq_not_from_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(!mode_off));

endmodule

bind tstamp_capture tstamp_capture_chk #(.TW(TW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .not_empty (not_empty),
  .overflow  (overflow),
  .irq       (irq),
  .mode_off  (mode_off)
);

// File: tb/tstamp_capture_tb.sv
module tstamp_capture_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cap_pin;
  logic [15:0] tmr_a, tmr_b;
  logic        ctl_wr;
  logic [5:0]  ctl_wdata;
  logic        rd_en;
  logic [15:0] rd_data;
  logic        not_empty, overflow, irq;

  always #4 clk = ~clk;  // 125 MHz

  tstamp_capture u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_pin   (cap_pin),
    .tmr_a     (tmr_a),
    .tmr_b     (tmr_b),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .not_empty (not_empty),
    .overflow  (overflow),
    .irq       (irq)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int irq_seen = 0;

  // reference model state
  logic [15:0] mq [4];
  int          mcnt = 0;
  bit          movf = 0;
  int          mpsc = 0, micnt = 0, mirq = 0;
  int          mmode = 0, mtsel = 0, mthr = 0;
  logic [15:0] last_rd = '0;
  int          seq = 0;

  always @(posedge clk) begin
    if (rst_n && irq) irq_seen <= irq_seen + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit is_off(int m);
    return (m == 0) || (m == 6) || (m == 7);
  endfunction

  task automatic check_status(input string ctx);
    check(not_empty == (mcnt != 0), {"R8 not_empty ", ctx}, 32'(not_empty), 32'(mcnt != 0));
    check(overflow == movf, {"R10 overflow ", ctx}, 32'(overflow), 32'(movf));
    check(irq_seen == mirq, {"R11 irq count ", ctx}, irq_seen, mirq);
    check(irq == 1'b0, {"R11 single-cycle pulse ", ctx}, 32'(irq), 0);
  endtask

  task automatic model_capture(input logic [15:0] v);
    if (mcnt < 4) begin
      mq[mcnt] = v;
      mcnt++;
      if (micnt >= mthr) begin
        mirq++;
        micnt = 0;
      end else begin
        micnt++;
      end
    end else begin
      movf = 1;
    end
  endtask

  task automatic ctl(input int m, input int ts, input int t);
    @(negedge clk);
    ctl_wr    = 1'b1;
    ctl_wdata = {t[1:0], ts[0], m[2:0]};
    @(negedge clk);
    ctl_wr = 1'b0;
    if (m != mmode) begin
      mpsc  = 0;
      micnt = 0;
    end
    mmode = m;
    mtsel = ts;
    mthr  = t;
    if (is_off(m)) begin
      mcnt = 0;
      movf = 0;
      mpsc = 0;
      micnt = 0;
    end
    @(negedge clk);
  endtask

  task automatic toggle(input string ctx);
    logic [15:0] v;
    bit r;
    @(negedge clk);
    seq++;
    tmr_a   = 16'h1000 + 16'(seq);
    tmr_b   = 16'h8000 ^ 16'(seq * 7);
    cap_pin = ~cap_pin;
    r = cap_pin;
    v = mtsel ? tmr_b : tmr_a;
    case (mmode)
      1: model_capture(v);
      2: if (!r) model_capture(v);
      3: if (r) model_capture(v);
      4, 5: if (r) begin
        mpsc++;
        if (mpsc == ((mmode == 4) ? 4 : 16)) begin
          mpsc = 0;
          model_capture(v);
        end
      end
      default: ;
    endcase
    repeat (4) @(negedge clk);
    check_status(ctx);
  endtask

  task automatic read(input string ctx);
    logic [15:0] exp;
    string tag;
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    if (mcnt > 0) begin
      exp = mq[0];
      for (int i = 0; i < 3; i++) mq[i] = mq[i+1];
      mcnt--;
      movf = 0;
      tag = {"R8 oldest-first ", ctx};
    end else begin
      exp = last_rd;
      tag = {"R9 empty read ", ctx};
    end
    check(rd_data == exp, tag, 32'(rd_data), 32'(exp));
    last_rd = exp;
    check_status(ctx);
  endtask

  initial begin
    string mtag;
    rst_n     = 1'b0;
    cap_pin   = 1'b0;
    tmr_a     = '0;
    tmr_b     = '0;
    ctl_wr    = 1'b0;
    ctl_wdata = '0;
    rd_en     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(not_empty == 1'b0, "R1 not_empty", 32'(not_empty), 0);
    check(overflow == 1'b0, "R1 overflow", 32'(overflow), 0);
    check(irq == 1'b0, "R1 irq", 32'(irq), 0);
    check(rd_data == 16'h0, "R1 rd_data", 32'(rd_data), 0);
    toggle("R1 off after reset");
    toggle("R1 off after reset");

    // R2 R3 R4 R7: edge modes over both sources
    for (int m = 1; m <= 3; m++) begin
      for (int ts = 0; ts <= 1; ts++) begin
        mtag = (m == 1) ? "R4" : (m == 2) ? "R3" : "R2";
        mtag = $sformatf("%s R7 tsel=%0d", mtag, ts);
        ctl(0, 0, 0);
        ctl(m, ts, 3);
        for (int k = 0; k < 3; k++) toggle(mtag);
        for (int k = 0; k < 4; k++) read(mtag);
      end
    end

    // R5: every 4th rising edge, divider restarts on mode change
    ctl(0, 0, 0);
    ctl(4, 0, 3);
    for (int k = 0; k < 4; k++) toggle("R5 partial");
    ctl(5, 0, 3);
    ctl(4, 0, 3);
    for (int k = 0; k < 24; k++) toggle("R5 div4");
    for (int k = 0; k < 4; k++) read("R5 div4");

    // R6: every 16th rising edge from tmr_b
    ctl(0, 0, 0);
    ctl(5, 1, 0);
    for (int k = 0; k < 40; k++) toggle("R6 div16");
    for (int k = 0; k < 2; k++) read("R6 div16");

    // R10: full buffer drops events and flags overflow
    ctl(0, 0, 0);
    ctl(3, 0, 3);
    for (int k = 0; k < 10; k++) toggle("R10 fill");
    read("R10 clear by pop");
    for (int k = 0; k < 2; k++) toggle("R10 refill");
    for (int k = 0; k < 2; k++) toggle("R10 overflow again");
    ctl(0, 0, 0);
    check_status("R12 flush on off");
    read("R12 R9 read after flush");

    // R12: off codes take nothing
    for (int m = 0; m < 8; m = (m == 0) ? 6 : m + 1) begin
      ctl(m, 0, 0);
      for (int k = 0; k < 4; k++) toggle($sformatf("R12 off code %0d", m));
      read($sformatf("R12 off code %0d", m));
    end

    // R11: threshold sweep and restart on mode change
    for (int t = 0; t < 4; t++) begin
      ctl(0, 0, 0);
      ctl(3, 0, t);
      for (int k = 0; k < 8; k++) toggle($sformatf("R11 thr=%0d", t));
      for (int k = 0; k < 4; k++) read($sformatf("R11 thr=%0d", t));
    end
    ctl(0, 0, 0);
    ctl(3, 0, 1);
    toggle("R11 restart a");
    toggle("R11 restart b");
    ctl(1, 0, 1);
    toggle("R11 restart after mode change");
    toggle("R11 restart after mode change");
    for (int k = 0; k < 3; k++) read("R11 restart");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule